// File: doc/BRIEF.md
# Gamut Remap Matrix

This block multiplies every RGB pixel of a stream by a 3x4 colour matrix. Each output channel is formed from three signed gains applied to the red, green and blue inputs plus a signed offset. The result is rounded to the nearest code and clamped to the pixel range. Two complete coefficient sets, A and B, are held in separate register windows. A requested-mode register chooses bypass, set A or set B.

The requested mode does not act directly on the pixels. It is copied into a current-mode register on a frame-start pulse, and the datapath uses only the current mode. Software can read the current mode, rewrite whichever set is idle, and then request a switch that takes effect cleanly at the next frame boundary.

Pixels travel with a valid flag through a fixed three-register pipeline. Bypass has the same latency as the matrix path.

Top module: `gamut_matrix`

## Requirements
- R1: `pix_valid_o` equals `pix_valid_i` delayed by exactly three rising clock edges. A pixel presented before edge n appears on the outputs just after edge n+2. Reset clears every pipeline valid.
- R2: While and after reset, both mode outputs read 0 and no output pixel is valid. All coefficients of both sets reset to zero, so a matrix mode selected before any coefficient write produces 0 on every channel.
- R3: A write to address 0 loads the requested mode from `cfg_wdata[1:0]`. The encoding is 0 = bypass, 1 = set A, 2 = set B. A written value of 3 is stored as 0.
- R4: On a rising edge with `frame_start` high, `mode_cur_o` takes the value `mode_req_o` held before that edge. Without `frame_start`, `mode_cur_o` holds its value.
- R5: When the current mode is 0, each output channel equals the same channel of the input, with the R1 latency.
- R6: Coefficients are 16-bit values in row-major order, indexed 0..11 as c11,c12,c13,c14,c21,...,c34. For k in 0..5, address 1+k writes set A and address 9+k writes set B. Each such write puts coefficient 2k in `cfg_wdata[15:0]` and coefficient 2k+1 in `cfg_wdata[31:16]`, so c11/c12 sit in the first word of a set and c33/c34 in its last word. Writes to addresses 7, 8 and 15 change nothing.
- R7: Coefficients are two's-complement with 13 fractional bits. Output channel i (i = 0 red, 1 green, 2 blue) is floor((ci1·R + ci2·G + ci3·B + ci4·2^PIX_W + 2^12) / 2^13), which rounds ties upward.
- R8: Matrix results below 0 give 0, and results above 2^PIX_W−1 give 2^PIX_W−1.
- R9: Current mode 1 applies set A and current mode 2 applies set B. The mode and coefficients in effect are those held when the pixel enters. Writing the idle set, or requesting a mode without a frame-start pulse, does not alter the pixels being produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register word address |
| cfg_wdata | input | 2*COEF_W | Register write data |
| frame_start | input | 1 | Frame boundary pulse; loads the current mode |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_r_i | input | PIX_W | Input red |
| pix_g_i | input | PIX_W | Input green |
| pix_b_i | input | PIX_W | Input blue |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_r_o | output | PIX_W | Output red |
| pix_g_o | output | PIX_W | Output green |
| pix_b_o | output | PIX_W | Output blue |
| mode_req_o | output | 2 | Requested mode |
| mode_cur_o | output | 2 | Mode currently applied to entering pixels |

## Verification
The assertions assume that the inputs hold steady around each rising edge and are known whenever reset is released. They also assume that `pix_valid_i` may be high on any cycle, so the latency checks compare against the input three edges earlier without requiring any gaps between pixels. The stimulus meets these assumptions by changing every input on the falling edge. It mixes directed pixels with a long stretch in which pixel valid, register writes to any address (including mode value 3 and unmapped words) and frame pulses are all drawn at random. Each output is compared every cycle with a behavioural model.

// File: rtl/gm_pkg.sv
package gm_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_SET_A  = 2'd1,
    MODE_SET_B  = 2'd2
  } gm_mode_e;

  localparam int unsigned N_ROW      = 3;
  localparam int unsigned N_COL      = 4;
  localparam int unsigned N_COEF     = N_ROW * N_COL;
  localparam int unsigned N_PAIR     = N_COEF / 2;
  localparam int unsigned N_SET      = 2;
  localparam int unsigned SET_BASE   = 1;   // first word of set A
  localparam int unsigned SET_STRIDE = 8;   // word distance between sets
endpackage

// File: rtl/gm_mode_ctrl.sv
module gm_mode_ctrl
  import gm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [1:0] ctl_wdata,
  input  logic       frame_start,
  output logic [1:0] mode_req,
  output logic [1:0] mode_cur
);
  logic [1:0] req_q, req_d, cur_q, cur_d;
  logic       req_en, cur_en;

  always_comb begin
    req_en = ctl_we;
    req_d  = (ctl_wdata == 2'd3) ? MODE_BYPASS : ctl_wdata;
    cur_en = frame_start;
    cur_d  = req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= MODE_BYPASS;
      cur_q <= MODE_BYPASS;
    end else begin
      if (req_en) req_q <= req_d;
      if (cur_en) cur_q <= cur_d;
    end
  end

  assign mode_req = req_q;
  assign mode_cur = cur_q;
endmodule

// File: rtl/gm_coef_bank.sv
module gm_coef_bank
  import gm_pkg::*;
#(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [2*COEF_W-1:0]                wdata,
  input  logic                               set_sel,
  output logic [N_COEF-1:0][COEF_W-1:0]      coef_o
);
  logic [COEF_W-1:0] bank [N_SET][N_COEF];

  for (genvar s = 0; s < N_SET; s++) begin : g_set
    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
      localparam int unsigned WORD = SET_BASE + s * SET_STRIDE + p;
      logic              hit;
      logic [COEF_W-1:0] lo_q, hi_q;

      assign hit = we && (addr == ADDR_W'(WORD));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lo_q <= '0;
          hi_q <= '0;
        end else if (hit) begin
          lo_q <= wdata[COEF_W-1:0];
          hi_q <= wdata[2*COEF_W-1:COEF_W];
        end
      end

      assign bank[s][2*p]   = lo_q;
      assign bank[s][2*p+1] = hi_q;
    end
  end

  always_comb begin
    for (int i = 0; i < N_COEF; i++) coef_o[i] = bank[set_sel][i];
  end
endmodule

// File: rtl/gm_channel.sv
module gm_channel #(
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned FRAC_W = 13,
  parameter int unsigned N_COL  = 4,
  parameter int unsigned CH     = 0
) (
  input  logic                          clk,
  input  logic                          s1_en,
  input  logic                          s2_en,
  input  logic                          s3_en,
  input  logic [2:0][PIX_W-1:0]         pix_i,
  input  logic [N_COL-1:0][COEF_W-1:0]  row_i,
  input  logic                          byp_i,
  output logic [PIX_W-1:0]              pix_o
);
  localparam int unsigned PROD_W = COEF_W + PIX_W + 1;
  localparam int unsigned ACC_W  = PROD_W + 2;
  localparam int unsigned SH_W   = ACC_W - FRAC_W;
  localparam logic signed [ACC_W-1:0] RND      = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [SH_W-1:0]  MAX_CODE = SH_W'((1 << PIX_W) - 1);

  // stage 1: products and scaled offset
  logic signed [PROD_W-1:0] prod_d [3];
  logic signed [PROD_W-1:0] prod_q [3];
  logic signed [PROD_W-1:0] ofs_d, ofs_q;
  logic                     byp1_q;
  logic [PIX_W-1:0]         thru1_q;
  // stage 2: sum, round, scale
  logic signed [ACC_W-1:0]  sum_d;
  logic signed [SH_W-1:0]   sh_d, sh_q;
  logic                     byp2_q;
  logic [PIX_W-1:0]         thru2_q;
  // stage 3: clamp
  logic [PIX_W-1:0]         out_d, out_q;

  always_comb begin
    for (int c = 0; c < 3; c++)
      prod_d[c] = PROD_W'($signed(row_i[c])) * PROD_W'($signed({1'b0, pix_i[c]}));
    ofs_d = PROD_W'($signed(row_i[3])) <<< PIX_W;
  end

  always_comb begin
    sum_d = ACC_W'(prod_q[0]) + ACC_W'(prod_q[1]) + ACC_W'(prod_q[2])
          + ACC_W'(ofs_q) + RND;
    sh_d  = SH_W'(sum_d >>> FRAC_W);
  end

  always_comb begin
    if (byp2_q)              out_d = thru2_q;
    else if (sh_q < 0)       out_d = '0;
    else if (sh_q > MAX_CODE) out_d = PIX_W'(MAX_CODE);
    else                     out_d = sh_q[PIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (s1_en) begin
      for (int c = 0; c < 3; c++) prod_q[c] <= prod_d[c];
      ofs_q   <= ofs_d;
      byp1_q  <= byp_i;
      thru1_q <= pix_i[CH];
    end
    if (s2_en) begin
      sh_q    <= sh_d;
      byp2_q  <= byp1_q;
      thru2_q <= thru1_q;
    end
    if (s3_en) out_q <= out_d;
  end

  assign pix_o = out_q;
endmodule

// File: rtl/gamut_matrix.sv
module gamut_matrix
  import gm_pkg::*;
#(
  parameter int unsigned PIX_W  = 10,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned FRAC_W = 13,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [2*COEF_W-1:0]   cfg_wdata,
  input  logic                  frame_start,
  input  logic                  pix_valid_i,
  input  logic [PIX_W-1:0]      pix_r_i,
  input  logic [PIX_W-1:0]      pix_g_i,
  input  logic [PIX_W-1:0]      pix_b_i,
  output logic                  pix_valid_o,
  output logic [PIX_W-1:0]      pix_r_o,
  output logic [PIX_W-1:0]      pix_g_o,
  output logic [PIX_W-1:0]      pix_b_o,
  output logic [1:0]            mode_req_o,
  output logic [1:0]            mode_cur_o
);
  localparam int unsigned DEPTH = 3;

  logic                            ctl_we;
  logic                            set_sel, byp;
  logic [N_COEF-1:0][COEF_W-1:0]   coef;
  logic [2:0][PIX_W-1:0]           pix_in;
  logic [2:0][PIX_W-1:0]           pix_out;
  logic [DEPTH-1:0]                vld_q, vld_d;

  assign ctl_we = cfg_we && (cfg_addr == '0);

  gm_mode_ctrl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we      (ctl_we),
    .ctl_wdata   (cfg_wdata[1:0]),
    .frame_start (frame_start),
    .mode_req    (mode_req_o),
    .mode_cur    (mode_cur_o)
  );

  assign set_sel = (mode_cur_o == MODE_SET_B);
  assign byp     = (mode_cur_o == MODE_BYPASS);

  gm_coef_bank #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .set_sel (set_sel),
    .coef_o  (coef)
  );

  always_comb vld_d = {vld_q[DEPTH-2:0], pix_valid_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign pix_in = {pix_b_i, pix_g_i, pix_r_i};

  for (genvar ch = 0; ch < N_ROW; ch++) begin : g_ch
    gm_channel #(
      .PIX_W (PIX_W), .COEF_W (COEF_W), .FRAC_W (FRAC_W),
      .N_COL (N_COL), .CH     (ch)
    ) u_ch (
      .clk   (clk),
      .s1_en (pix_valid_i),
      .s2_en (vld_q[0]),
      .s3_en (vld_q[1]),
      .pix_i (pix_in),
      .row_i (coef[ch*N_COL +: N_COL]),
      .byp_i (byp),
      .pix_o (pix_out[ch])
    );
  end

  assign pix_valid_o = vld_q[DEPTH-1];
  assign pix_r_o     = pix_out[0];
  assign pix_g_o     = pix_out[1];
  assign pix_b_o     = pix_out[2];
endmodule

// File: rtl/gm_checker.sv
module gm_checker #(
  parameter int unsigned PIX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             pix_valid_i,
  input logic [PIX_W-1:0] pix_r_i,
  input logic [PIX_W-1:0] pix_b_i,
  input logic             pix_valid_o,
  input logic [PIX_W-1:0] pix_r_o,
  input logic [PIX_W-1:0] pix_b_o,
  input logic [1:0]       mode_req_o,
  input logic [1:0]       mode_cur_o
);
  logic [1:0] seen_q;
  logic       ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             seen_q <= '0;
    else if (seen_q != 2'd3) seen_q <= seen_q + 2'd1;
  end
  assign ready = (seen_q == 2'd3);

  // R1: valid latency
  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (pix_valid_o == $past(pix_valid_i, 3)));

  // R3: encoding 3 never held
  a_r3_no_mode3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req_o != 2'd3) && (mode_cur_o != 2'd3));

  // R4: load on frame pulse
  a_r4_cur_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (mode_cur_o == $past(mode_req_o)));

  // R4: hold without frame pulse
  a_r4_cur_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_cur_o));

  // R5: bypass passes pixels unchanged
  a_r5_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pix_valid_o && ($past(mode_cur_o, 3) == 2'd0))
      |-> ((pix_r_o == $past(pix_r_i, 3)) && (pix_b_o == $past(pix_b_i, 3))));
endmodule

bind gamut_matrix gm_checker #(.PIX_W(PIX_W)) u_gm_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .pix_valid_i (pix_valid_i),
  .pix_r_i     (pix_r_i),
  .pix_b_i     (pix_b_i),
  .pix_valid_o (pix_valid_o),
  .pix_r_o     (pix_r_o),
  .pix_b_o     (pix_b_o),
  .mode_req_o  (mode_req_o),
  .mode_cur_o  (mode_cur_o)
);

// File: tb/gamut_matrix_bench.sv
`timescale 1ns/1ps
module gamut_matrix_bench;
  localparam int PIX_W = 10;
  localparam int COEF_W = 16;
  localparam int FRAC_W = 13;
  localparam int ADDR_W = 4;
  localparam int MAXC = (1 << PIX_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [ADDR_W-1:0] cfg_addr;
  logic [2*COEF_W-1:0] cfg_wdata;
  logic frame_start;
  logic pix_valid_i;
  logic [PIX_W-1:0] pix_r_i, pix_g_i, pix_b_i;
  logic pix_valid_o;
  logic [PIX_W-1:0] pix_r_o, pix_g_o, pix_b_o;
  logic [1:0] mode_req_o, mode_cur_o;

  always #5 clk = ~clk;

  gamut_matrix #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W))
  u_gamut_matrix (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frame_start(frame_start), .pix_valid_i(pix_valid_i),
    .pix_r_i(pix_r_i), .pix_g_i(pix_g_i), .pix_b_i(pix_b_i),
    .pix_valid_o(pix_valid_o), .pix_r_o(pix_r_o), .pix_g_o(pix_g_o),
    .pix_b_o(pix_b_o), .mode_req_o(mode_req_o), .mode_cur_o(mode_cur_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit mdl_on = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_coef [2][12];
  int m_req, m_cur;
  bit m_vld [3];
  bit m_byp [3];
  int m_px  [3][3];

  function automatic int mdl_chan(int c1, int c2, int c3, int c4, int r, int g, int b);
    longint acc, q;
    acc = longint'(c1) * r + longint'(c2) * g + longint'(c3) * b
        + longint'(c4) * (longint'(1) << PIX_W) + (longint'(1) << (FRAC_W - 1));
    q = acc >>> FRAC_W;
    if (q < 0) return 0;
    if (q > MAXC) return MAXC;
    return int'(q);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req <= 0; m_cur <= 0;
      for (int s = 0; s < 2; s++) for (int i = 0; i < 12; i++) m_coef[s][i] <= 0;
      for (int k = 0; k < 3; k++) begin
        m_vld[k] <= 0; m_byp[k] <= 0;
        for (int c = 0; c < 3; c++) m_px[k][c] <= 0;
      end
    end else begin
      if (cfg_we) begin
        int a;
        a = int'(cfg_addr);
        if (a == 0) m_req <= (cfg_wdata[1:0] == 2'd3) ? 0 : int'(cfg_wdata[1:0]);
        for (int s = 0; s < 2; s++)
          if (a >= 1 + 8*s && a <= 6 + 8*s) begin
            m_coef[s][2*(a-1-8*s)]   <= int'($signed(cfg_wdata[15:0]));
            m_coef[s][2*(a-1-8*s)+1] <= int'($signed(cfg_wdata[31:16]));
          end
      end
      if (frame_start) m_cur <= m_req;
      m_vld[0] <= pix_valid_i;
      m_vld[1] <= m_vld[0];
      m_vld[2] <= m_vld[1];
      if (pix_valid_i) begin
        m_byp[0] <= (m_cur == 0);
        if (m_cur == 0) begin
          m_px[0][0] <= int'(pix_r_i); m_px[0][1] <= int'(pix_g_i); m_px[0][2] <= int'(pix_b_i);
        end else begin
          for (int c = 0; c < 3; c++)
            m_px[0][c] <= mdl_chan(m_coef[m_cur-1][4*c], m_coef[m_cur-1][4*c+1],
                                   m_coef[m_cur-1][4*c+2], m_coef[m_cur-1][4*c+3],
                                   int'(pix_r_i), int'(pix_g_i), int'(pix_b_i));
        end
      end
      m_byp[1] <= m_byp[0]; m_byp[2] <= m_byp[1];
      m_px[1] <= m_px[0];   m_px[2] <= m_px[1];
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && mdl_on && !done) begin
      chk(pix_valid_o == m_vld[2], "R1", "valid", int'(pix_valid_o), int'(m_vld[2]));
      chk(int'(mode_req_o) == m_req, "R3", "mode_req", int'(mode_req_o), m_req);
      chk(int'(mode_cur_o) == m_cur, "R4", "mode_cur", int'(mode_cur_o), m_cur);
      if (m_vld[2]) begin
        chk(int'(pix_r_o) == m_px[2][0], m_byp[2] ? "R5" : "R7", "red",   int'(pix_r_o), m_px[2][0]);
        chk(int'(pix_g_o) == m_px[2][1], m_byp[2] ? "R5" : "R7", "green", int'(pix_g_o), m_px[2][1]);
        chk(int'(pix_b_o) == m_px[2][2], m_byp[2] ? "R5" : "R7", "blue",  int'(pix_b_o), m_px[2][2]);
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input int a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = ADDR_W'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic px(input int r, input int g, input int b,
                    input int er, input int eg, input int eb, input string req);
    pix_valid_i = 1'b1;
    pix_r_i = PIX_W'(r); pix_g_i = PIX_W'(g); pix_b_i = PIX_W'(b);
    @(negedge clk);
    pix_valid_i = 1'b0;
    @(negedge clk);
    chk(pix_valid_o == 1'b0, "R1", "valid early", int'(pix_valid_o), 0);
    @(negedge clk);
    chk(pix_valid_o == 1'b1, "R1", "valid at third edge", int'(pix_valid_o), 1);
    chk(int'(pix_r_o) == er, req, "red",   int'(pix_r_o), er);
    chk(int'(pix_g_o) == eg, req, "green", int'(pix_g_o), eg);
    chk(int'(pix_b_o) == eb, req, "blue",  int'(pix_b_o), eb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; frame_start = 1'b0;
    pix_valid_i = 1'b0; pix_r_i = '0; pix_g_i = '0; pix_b_i = '0;
    repeat (3) @(negedge clk);
    // R2: state during reset
    chk(pix_valid_o == 1'b0, "R2", "valid in reset", int'(pix_valid_o), 0);
    chk(mode_req_o == 2'd0, "R2", "req in reset", int'(mode_req_o), 0);
    chk(mode_cur_o == 2'd0, "R2", "cur in reset", int'(mode_cur_o), 0);
    rst_n = 1'b1;
    mdl_on = 1;
    @(negedge clk);

    // R5: bypass after reset
    px(100, 200, 300, 100, 200, 300, "R5");
    px(0, 1023, 512, 0, 1023, 512, "R5");

    // R3/R4: request set A, not yet current
    wr(0, 32'd1);
    chk(mode_req_o == 2'd1, "R3", "req after write", int'(mode_req_o), 1);
    chk(mode_cur_o == 2'd0, "R4", "cur before frame", int'(mode_cur_o), 0);
    px(7, 8, 9, 7, 8, 9, "R9");
    frame();
    chk(mode_cur_o == 2'd1, "R4", "cur after frame", int'(mode_cur_o), 1);
    // R2: zero coefficients after reset
    px(500, 600, 700, 0, 0, 0, "R2");

    // R6: identity into set A (c11 word1 low, c22 word3 high, c33 word6 low)
    wr(1, 32'h0000_2000);
    wr(3, 32'h2000_0000);
    wr(6, 32'h0000_2000);
    px(11, 22, 1023, 11, 22, 1023, "R6");
    // R6: unmapped words ignored
    wr(7, 32'hFFFF_FFFF);
    wr(8, 32'h1234_5678);
    wr(15, 32'h8000_8000);
    px(40, 50, 60, 40, 50, 60, "R6");

    // set B while A is current: idle set write must not disturb (R9)
    wr(9,  32'h0000_1000);   // c11 = 0.5
    wr(11, 32'hE000_0000);   // c22 = -1.0
    wr(12, 32'h2000_0000);   // c24 = +1.0 offset
    wr(14, 32'h0000_3000);   // c33 = 1.5
    wr(0, 32'd2);
    px(3, 4, 5, 3, 4, 5, "R9");
    frame();
    chk(mode_cur_o == 2'd2, "R4", "cur set B", int'(mode_cur_o), 2);
    // R7 rounding, R8 high clamp
    px(3, 0, 1000, 2, 1023, 1023, "R8");
    px(1, 500, 100, 1, 524, 150, "R7");
    px(0, 1023, 0, 0, 1, 0, "R7");

    // R8: low clamp with negative gain in set A
    wr(0, 32'd1);
    frame();
    wr(1, 32'h0000_E000);    // c11 = -1.0
    px(5, 6, 7, 0, 6, 7, "R8");

    // R3: value 3 stored as bypass
    wr(0, 32'd3);
    chk(mode_req_o == 2'd0, "R3", "mode 3 coerced", int'(mode_req_o), 0);
    frame();
    px(9, 10, 11, 9, 10, 11, "R5");

    // random phase checked against the model every clock (R1,R3..R9)
    for (int i = 0; i < 3000; i++) begin
      pix_valid_i = 1'($urandom % 2);
      pix_r_i = PIX_W'($urandom); pix_g_i = PIX_W'($urandom); pix_b_i = PIX_W'($urandom);
      cfg_we = (($urandom % 6) == 0);
      cfg_addr = ADDR_W'($urandom);
      cfg_wdata = $urandom;
      frame_start = (($urandom % 12) == 0);
      @(negedge clk);
    end
    pix_valid_i = 1'b0; cfg_we = 1'b0; frame_start = 1'b0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule